// File: doc/BRIEF.md
# Serial Display Link Training Sequencer

This block brings up a multi-lane serial display link. After a start request it programs the sink's link settings, then runs two phases. The first is clock recovery, which uses training pattern 1. The second is channel equalization, which uses training pattern 2. In each iteration the block drives the pattern and the drive levels to the transmitter, copies the pattern select and the per-lane training bytes into the sink, waits a fixed number of microsecond ticks, and reads the sink's six lane status bytes.

Every sink access goes to an external auxiliary-channel engine through a level request that is held until a done pulse arrives. When an iteration does not pass, the sink's per-lane adjust requests are merged into one shared drive setting, capped to what the transmitter can produce. Whatever the outcome, the block always ends by turning the transmitter pattern off and writing pattern-disable to the sink. It then reports clock-recovery success, equalization success, or failure.

Top module: `lt_train_ctrl`

## Requirements
- R1: On `start`, the first access is a 9-byte write at address 0x100. Byte 0 is `link_rate`, byte 1 is `lane_cnt` with bit 7 set when `sink_rev` >= 0x11, and bytes 2 to 8 are zero.
- R2: Each clock-recovery iteration drives `tx_pattern`=1 (the encoding is 0 off, 1 pattern 1, 2 pattern 2). It writes 1 byte of value 1 to 0x102, then writes 4 bytes to 0x103, waits CR_WAIT_US (100) ticks of `tick_us`, and then issues a 6-byte read at 0x202.
- R3: Lane n's status nibble sits in status byte n/2 at bit 4*(n&1), with bit 0 meaning CR done, bit 1 EQ done and bit 2 symbol locked. Only lanes n < `lane_cnt` count. Clock recovery passes when every active lane has CR done, and the block then sets `cr_ok` and enters equalization.
- R4: The training byte holds swing in [1:0], a max-swing flag in bit 2, pre-emphasis in [4:3] and a max-pre-emphasis flag in bit 5. It starts at zero. All four lane bytes written to 0x103, and `tx_swing`/`tx_preemph`, carry that one shared value.
- R5: A failed iteration builds the next training byte from the largest swing and the largest pre-emphasis requested by any active lane. Lane n's adjust field is in status byte 4+n/2: an even lane uses [1:0] swing and [3:2] pre-emphasis, an odd lane uses [5:4] and [7:6]. Swing is capped at 2 and sets the flag when it reaches the cap. The pre-emphasis limit is 2 for swing 0 or 1, 1 for swing 2 and 0 for swing 3, and the flag is set when the limit is reached.
- R6: Clock recovery ends without success when a failing iteration's applied training byte has the max-swing flag set.
- R7: Clock recovery ends without success on the fifth consecutive iteration whose applied swing equals that of the previous iteration. The repeat count restarts whenever the swing changes.
- R8: Each equalization iteration drives `tx_pattern`=2, writes value 2 to 0x102 and the lane bytes to 0x103, waits EQ_WAIT_US (400) ticks and reads the status. It passes only when status byte 2 bit 0 (interlane align) is set and every active lane has CR done, EQ done and symbol locked.
- R9: A failing equalization iteration retries while its retry count is 5 or less. The 7th consecutive failing status read therefore ends training.
- R10: Equalization runs only after clock recovery passes. Every run ends with `tx_pattern`=0 and a 1-byte write of 0 to 0x102. This is followed by a one-cycle `done` with `cr_ok`/`eq_ok` held and `train_fail` = not `eq_ok`.
- R11: An access completed with `aux_err` ends the current phase at once and goes to the closing sequence of R10.
- R12: `aux_req` is low while idle, and once raised it holds its address and direction until `aux_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin training (sampled when idle) |
| link_rate | input | 8 | Link rate code sent in config byte 0 |
| lane_cnt | input | 3 | Active lanes: 1, 2 or 4 |
| sink_rev | input | 8 | Sink revision, enables enhanced framing at 0x11 and above |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| aux_req | output | 1 | Access request, held until done |
| aux_rd | output | 1 | 1 read, 0 write |
| aux_addr | output | 16 | Sink address |
| aux_len | output | 4 | Byte count |
| aux_wdata | output | 72 | Write bytes, byte i at [8i+7:8i] |
| aux_done | input | 1 | Access complete pulse |
| aux_err | input | 1 | Access failed, valid with aux_done |
| aux_rdata | input | 48 | Read bytes, valid with aux_done |
| tx_pattern | output | 2 | Transmitter pattern select |
| tx_swing | output | 2 | Transmitter swing level |
| tx_preemph | output | 2 | Transmitter pre-emphasis level |
| busy | output | 1 | Training in progress |
| done | output | 1 | One-cycle completion pulse |
| cr_ok | output | 1 | Clock recovery succeeded |
| eq_ok | output | 1 | Equalization succeeded |
| train_fail | output | 1 | Training did not complete |

## Verification
The properties assume that the auxiliary engine raises `aux_done` only while `aux_req` is high and for a single cycle, and that `aux_err` and `aux_rdata` count only alongside `aux_done`. The bench's responder notices a request at a falling edge, waits two cycles, pulses done for one cycle, and then looks for the next request. This keeps every access inside that contract. `tick_us` runs free at half the clock rate, so the waits are counted in ticks and not in cycles. Sink status is scripted per read, and it covers lane-mask boundaries, the caps, the repeat reset, the retry limit and an error completion.

// File: rtl/lt_pkg.sv
package lt_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CFG, S_CR_PAT, S_CR_LANE, S_CR_WAIT, S_CR_READ, S_CR_EVAL,
    S_EQ_PAT, S_EQ_LANE, S_EQ_WAIT, S_EQ_READ, S_EQ_EVAL, S_FIN, S_DONE
  } lt_state_e;

  localparam logic [15:0] ADDR_CFG  = 16'h0100;
  localparam logic [15:0] ADDR_PAT  = 16'h0102;
  localparam logic [15:0] ADDR_LANE = 16'h0103;
  localparam logic [15:0] ADDR_STAT = 16'h0202;
  localparam logic [1:0]  SWING_CAP = 2'd2;

  // highest pre-emphasis code allowed for a given swing code
  function automatic logic [1:0] pre_limit(input logic [1:0] sw);
    case (sw)
      2'd0, 2'd1: pre_limit = 2'd2;
      2'd2:       pre_limit = 2'd1;
      default:    pre_limit = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/lt_delay.sv
module lt_delay #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                    cnt_d = load_val;
    else if (tick && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/lt_lane_eval.sv
module lt_lane_eval
  import lt_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int LW         = 3,
  parameter int STAT_BYTES = 6
) (
  input  logic [8*STAT_BYTES-1:0] stat,
  input  logic [LW-1:0]           lanes,
  output logic                    cr_pass,
  output logic                    eq_pass,
  output logic [7:0]              next_train
);
  localparam int LANE_BYTES = (NUM_LANES + 1) / 2;
  localparam int ALIGN_IDX  = LANE_BYTES;
  localparam int ADJ_BASE   = LANE_BYTES + 2;

  logic [3:0] nib, adj;
  logic [1:0] max_sw, max_pe, sw, pe, lim;
  logic       sw_flag, pe_flag;
  logic       unused_stat;

  assign unused_stat = ^stat[8*ALIGN_IDX+1 +: 15];

  always_comb begin
    cr_pass = 1'b1;
    eq_pass = stat[8*ALIGN_IDX];
    max_sw  = 2'd0;
    max_pe  = 2'd0;
    nib     = 4'd0;
    adj     = 4'd0;
    for (int n = 0; n < NUM_LANES; n++) begin
      if (LW'(n) < lanes) begin
        nib     = stat[8*(n/2) + 4*(n%2) +: 4];
        adj     = stat[8*(ADJ_BASE + n/2) + 4*(n%2) +: 4];
        cr_pass = cr_pass & nib[0];
        eq_pass = eq_pass & (&nib[2:0]);
        if (adj[1:0] > max_sw) max_sw = adj[1:0];
        if (adj[3:2] > max_pe) max_pe = adj[3:2];
      end
    end
    sw      = max_sw;
    sw_flag = 1'b0;
    if (sw >= SWING_CAP) begin
      sw      = SWING_CAP;
      sw_flag = 1'b1;
    end
    lim     = pre_limit(sw);
    pe      = max_pe;
    pe_flag = 1'b0;
    if (pe >= lim) begin
      pe      = lim;
      pe_flag = 1'b1;
    end
    next_train = {2'b00, pe_flag, pe, sw_flag, sw};
  end
endmodule

// File: rtl/lt_train_ctrl.sv
module lt_train_ctrl
  import lt_pkg::*;
#(
  parameter int NUM_LANES      = 4,
  parameter int CFG_BYTES      = 9,
  parameter int CR_WAIT_US     = 100,
  parameter int EQ_WAIT_US     = 400,
  parameter int REPEAT_LIMIT   = 5,
  parameter int EQ_RETRY_LIMIT = 5,
  localparam int LW         = $clog2(NUM_LANES + 1),
  localparam int STAT_BYTES = 2 * ((NUM_LANES + 1) / 2) + 2,
  localparam int LENW       = $clog2(CFG_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [7:0]              link_rate,
  input  logic [LW-1:0]           lane_cnt,
  input  logic [7:0]              sink_rev,
  input  logic                    tick_us,
  output logic                    aux_req,
  output logic                    aux_rd,
  output logic [15:0]             aux_addr,
  output logic [LENW-1:0]         aux_len,
  output logic [8*CFG_BYTES-1:0]  aux_wdata,
  input  logic                    aux_done,
  input  logic                    aux_err,
  input  logic [8*STAT_BYTES-1:0] aux_rdata,
  output logic [1:0]              tx_pattern,
  output logic [1:0]              tx_swing,
  output logic [1:0]              tx_preemph,
  output logic                    busy,
  output logic                    done,
  output logic                    cr_ok,
  output logic                    eq_ok,
  output logic                    train_fail
);
  localparam int WAIT_MAX = (CR_WAIT_US > EQ_WAIT_US) ? CR_WAIT_US : EQ_WAIT_US;
  localparam int CW       = $clog2(WAIT_MAX + 1);
  localparam int TRY_MAX  = (REPEAT_LIMIT > EQ_RETRY_LIMIT) ? REPEAT_LIMIT : EQ_RETRY_LIMIT;
  localparam int TW       = $clog2(TRY_MAX + 2);

  lt_state_e              state_q, state_d;
  logic [7:0]             train_q, train_d, rate_q, rate_d;
  logic [LW-1:0]          lanes_q, lanes_d;
  logic                   enh_q, enh_d, prev_v_q, prev_v_d;
  logic [1:0]             prev_sw_q, prev_sw_d, pat_q, pat_d;
  logic [TW-1:0]          tries_q, tries_d;
  logic [8*STAT_BYTES-1:0] stat_q, stat_d;
  logic                   cr_ok_q, cr_ok_d, eq_ok_q, eq_ok_d, fail_q, fail_d;
  logic                   dly_load, dly_exp;
  logic [CW-1:0]          dly_val;
  logic                   cr_pass, eq_pass, same_sw;
  logic [7:0]             next_train;

  lt_delay #(.CW(CW)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(dly_val),
    .tick(tick_us), .expired(dly_exp)
  );

  lt_lane_eval #(.NUM_LANES(NUM_LANES), .LW(LW), .STAT_BYTES(STAT_BYTES)) u_eval (
    .stat(stat_q), .lanes(lanes_q), .cr_pass(cr_pass), .eq_pass(eq_pass),
    .next_train(next_train)
  );

  assign same_sw = prev_v_q && (prev_sw_q == train_q[1:0]);

  // access decode
  always_comb begin
    aux_req   = 1'b1;
    aux_rd    = 1'b0;
    aux_addr  = ADDR_PAT;
    aux_len   = LENW'(1);
    aux_wdata = '0;
    case (state_q)
      S_CFG: begin
        aux_addr         = ADDR_CFG;
        aux_len          = LENW'(CFG_BYTES);
        aux_wdata[7:0]   = rate_q;
        aux_wdata[15:8]  = 8'(lanes_q) | {enh_q, 7'b0};
      end
      S_CR_PAT: aux_wdata[7:0] = 8'd1;
      S_EQ_PAT: aux_wdata[7:0] = 8'd2;
      S_FIN:    aux_wdata[7:0] = 8'd0;
      S_CR_LANE, S_EQ_LANE: begin
        aux_addr = ADDR_LANE;
        aux_len  = LENW'(NUM_LANES);
        for (int i = 0; i < NUM_LANES; i++) aux_wdata[8*i +: 8] = train_q;
      end
      S_CR_READ, S_EQ_READ: begin
        aux_rd   = 1'b1;
        aux_addr = ADDR_STAT;
        aux_len  = LENW'(STAT_BYTES);
      end
      default: aux_req = 1'b0;
    endcase
  end

  // next state
  always_comb begin
    state_d   = state_q;
    train_d   = train_q;
    rate_d    = rate_q;
    lanes_d   = lanes_q;
    enh_d     = enh_q;
    prev_v_d  = prev_v_q;
    prev_sw_d = prev_sw_q;
    tries_d   = tries_q;
    stat_d    = stat_q;
    cr_ok_d   = cr_ok_q;
    eq_ok_d   = eq_ok_q;
    fail_d    = fail_q;
    pat_d     = pat_q;
    dly_load  = 1'b0;
    dly_val   = CW'(CR_WAIT_US);
    case (state_q)
      S_IDLE: if (start) begin
        rate_d   = link_rate;
        lanes_d  = lane_cnt;
        enh_d    = (sink_rev >= 8'h11);
        train_d  = 8'd0;
        prev_v_d = 1'b0;
        tries_d  = '0;
        cr_ok_d  = 1'b0;
        eq_ok_d  = 1'b0;
        fail_d   = 1'b0;
        state_d  = S_CFG;
      end
      S_CFG:     if (aux_done) state_d = S_CR_PAT;
      S_CR_PAT:  if (aux_done) state_d = S_CR_LANE;
      S_CR_LANE: if (aux_done) begin
        state_d  = S_CR_WAIT;
        dly_load = 1'b1;
      end
      S_CR_WAIT: if (dly_exp) state_d = S_CR_READ;
      S_CR_READ: if (aux_done) begin
        stat_d  = aux_rdata;
        state_d = S_CR_EVAL;
      end
      S_CR_EVAL: begin
        if (cr_pass) begin
          cr_ok_d = 1'b1;
          tries_d = '0;
          state_d = S_EQ_PAT;
        end else if (train_q[2]) begin
          state_d = S_FIN;
        end else if (same_sw && tries_q == TW'(REPEAT_LIMIT - 1)) begin
          state_d = S_FIN;
        end else begin
          tries_d   = same_sw ? tries_q + 1'b1 : '0;
          prev_v_d  = 1'b1;
          prev_sw_d = train_q[1:0];
          train_d   = next_train;
          state_d   = S_CR_PAT;
        end
      end
      S_EQ_PAT:  if (aux_done) state_d = S_EQ_LANE;
      S_EQ_LANE: if (aux_done) begin
        state_d  = S_EQ_WAIT;
        dly_load = 1'b1;
        dly_val  = CW'(EQ_WAIT_US);
      end
      S_EQ_WAIT: if (dly_exp) state_d = S_EQ_READ;
      S_EQ_READ: if (aux_done) begin
        stat_d  = aux_rdata;
        state_d = S_EQ_EVAL;
      end
      S_EQ_EVAL: begin
        if (eq_pass) begin
          eq_ok_d = 1'b1;
          state_d = S_FIN;
        end else if (tries_q > TW'(EQ_RETRY_LIMIT)) begin
          state_d = S_FIN;
        end else begin
          train_d = next_train;
          tries_d = tries_q + 1'b1;
          state_d = S_EQ_PAT;
        end
      end
      S_FIN: if (aux_done) begin
        fail_d  = !eq_ok_q;
        state_d = S_DONE;
      end
      default: state_d = S_IDLE;
    endcase
    // an errored access abandons the running phase
    if (aux_req && aux_done && aux_err && state_q != S_FIN) state_d = S_FIN;
    if (state_d != state_q) begin
      if (state_d == S_CR_PAT)      pat_d = 2'd1;
      else if (state_d == S_EQ_PAT) pat_d = 2'd2;
      else if (state_d == S_FIN)    pat_d = 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      train_q   <= '0;
      rate_q    <= '0;
      lanes_q   <= '0;
      enh_q     <= 1'b0;
      prev_v_q  <= 1'b0;
      prev_sw_q <= '0;
      tries_q   <= '0;
      stat_q    <= '0;
      cr_ok_q   <= 1'b0;
      eq_ok_q   <= 1'b0;
      fail_q    <= 1'b0;
      pat_q     <= '0;
    end else begin
      state_q   <= state_d;
      train_q   <= train_d;
      rate_q    <= rate_d;
      lanes_q   <= lanes_d;
      enh_q     <= enh_d;
      prev_v_q  <= prev_v_d;
      prev_sw_q <= prev_sw_d;
      tries_q   <= tries_d;
      stat_q    <= stat_d;
      cr_ok_q   <= cr_ok_d;
      eq_ok_q   <= eq_ok_d;
      fail_q    <= fail_d;
      pat_q     <= pat_d;
    end
  end

  assign tx_pattern = pat_q;
  assign tx_swing   = train_q[1:0];
  assign tx_preemph = train_q[4:3];
  assign busy       = (state_q != S_IDLE);
  assign done       = (state_q == S_DONE);
  assign cr_ok      = cr_ok_q;
  assign eq_ok      = eq_ok_q;
  assign train_fail = fail_q;
endmodule

// File: rtl/lt_train_chk.sv
module lt_train_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        aux_req,
  input logic        aux_rd,
  input logic [15:0] aux_addr,
  input logic        aux_done,
  input logic [1:0]  tx_pattern,
  input logic [1:0]  tx_swing,
  input logic [1:0]  tx_preemph,
  input logic        busy,
  input logic        done,
  input logic        cr_ok,
  input logic        eq_ok
);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_req && !aux_done) |=> (aux_req && $stable(aux_addr) && $stable(aux_rd)));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !aux_req);

  p_swing_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_swing != 2'd3);

  p_pre_cap_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_swing == 2'd2) |-> (tx_preemph <= 2'd1));

  p_pre_cap_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_swing < 2'd2) |-> (tx_preemph <= 2'd2));

  p_pattern_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pattern != 2'd3);

  p_done_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tx_pattern == 2'd0 && !aux_req));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_eq_after_cr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eq_ok |-> cr_ok);
endmodule

bind lt_train_ctrl lt_train_chk u_chk (
  .clk(clk), .rst_n(rst_n), .aux_req(aux_req), .aux_rd(aux_rd),
  .aux_addr(aux_addr), .aux_done(aux_done), .tx_pattern(tx_pattern),
  .tx_swing(tx_swing), .tx_preemph(tx_preemph), .busy(busy), .done(done),
  .cr_ok(cr_ok), .eq_ok(eq_ok)
);

// File: tb/tb_lt_train_ctrl.sv
module tb_lt_train_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, start, tick_us, aux_done, aux_err;
  logic [7:0]  link_rate, sink_rev;
  logic [2:0]  lane_cnt;
  logic [47:0] aux_rdata;
  logic        aux_req, aux_rd, busy, done, cr_ok, eq_ok, train_fail;
  logic [15:0] aux_addr;
  logic [3:0]  aux_len;
  logic [71:0] aux_wdata;
  logic [1:0]  tx_pattern, tx_swing, tx_preemph;

  int checks = 0, fails = 0, tick_total = 0;

  always #2.5 clk = ~clk;

  lt_train_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start(start), .link_rate(link_rate),
    .lane_cnt(lane_cnt), .sink_rev(sink_rev), .tick_us(tick_us),
    .aux_req(aux_req), .aux_rd(aux_rd), .aux_addr(aux_addr), .aux_len(aux_len),
    .aux_wdata(aux_wdata), .aux_done(aux_done), .aux_err(aux_err),
    .aux_rdata(aux_rdata), .tx_pattern(tx_pattern), .tx_swing(tx_swing),
    .tx_preemph(tx_preemph), .busy(busy), .done(done), .cr_ok(cr_ok),
    .eq_ok(eq_ok), .train_fail(train_fail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    tick_us = 1'b0;
    forever begin
      @(negedge clk);
      tick_us = ~tick_us;
      if (tick_us) tick_total++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  // scripted sink status per scenario, phase and read index
  function automatic logic [47:0] sink_stat(input int sc, input bit eq, input int idx);
    logic [7:0] b [6];
    for (int i = 0; i < 6; i++) b[i] = 8'h00;
    case (sc)
      0, 6: if (!eq) begin b[0] = 8'h11; b[1] = 8'h11; end
            else begin b[0] = 8'h77; b[1] = 8'h77; b[2] = 8'h01; end
      1: if (!eq) begin
           if (idx == 0) begin b[4] = 8'hD1; b[5] = 8'hF4; end
           else begin b[0] = 8'h11; b[1] = 8'h11; end
         end else begin
           if (idx == 0) begin b[0] = 8'h77; b[1] = 8'h77; end
           else if (idx == 1) begin b[0] = 8'h37; b[1] = 8'h77; b[2] = 8'h01; b[4] = 8'h06; end
           else begin b[0] = 8'h77; b[1] = 8'h77; b[2] = 8'h01; end
         end
      3: b[4] = 8'h03;
      4: if (!eq) begin b[0] = 8'h11; b[1] = 8'h11; end
         else begin b[0] = 8'h33; b[1] = 8'h33; b[2] = 8'h01; end
      7: b[4] = (idx >= 2) ? 8'h01 : 8'h00;
      default: ;
    endcase
    return {b[5], b[4], b[3], b[2], b[1], b[0]};
  endfunction

  function automatic int nib(input logic [47:0] st, input int byte_idx, input int n);
    int b = int'(st[8*byte_idx +: 8]);
    return (n % 2 == 1) ? ((b >> 4) & 15) : (b & 15);
  endfunction

  function automatic bit exp_pass(input logic [47:0] st, input int lanes, input bit eq);
    bit ok = eq ? st[16] : 1'b1;
    for (int n = 0; n < lanes; n++) begin
      int f = nib(st, n / 2, n);
      if (eq) ok = ok && ((f & 7) == 7);
      else    ok = ok && ((f & 1) == 1);
    end
    return ok;
  endfunction

  function automatic logic [7:0] exp_adjust(input logic [47:0] st, input int lanes);
    int sw = 0, pe = 0, lim;
    bit fs = 0, fp = 0;
    for (int n = 0; n < lanes; n++) begin
      int f = nib(st, 4 + n / 2, n);
      if ((f & 3) > sw) sw = f & 3;
      if (((f >> 2) & 3) > pe) pe = (f >> 2) & 3;
    end
    if (sw >= 2) begin sw = 2; fs = 1; end
    lim = (sw == 3) ? 0 : (sw == 2) ? 1 : 2;
    if (pe >= lim) begin pe = lim; fp = 1; end
    return 8'(sw | (int'(fs) << 2) | (pe << 3) | (int'(fp) << 5));
  endfunction

  // expected {cr reads, eq reads, cr_ok, eq_ok}
  task automatic expect_out(input int sc, input int lanes, output int crn, output int eqn,
                            output bit cro, output bit eqo);
    case (sc)
      0, 6: begin crn = 1; eqn = 1; cro = 1; eqo = 1; end
      1:    begin crn = 2; eqn = (lanes == 1) ? 2 : 3; cro = 1; eqo = 1; end
      2:    begin crn = 6; eqn = 0; cro = 0; eqo = 0; end
      3:    begin crn = 2; eqn = 0; cro = 0; eqo = 0; end
      4:    begin crn = 1; eqn = 7; cro = 1; eqo = 0; end
      5:    begin crn = 1; eqn = 0; cro = 0; eqo = 0; end
      default: begin crn = 9; eqn = 0; cro = 0; eqo = 0; end
    endcase
  endtask

  task automatic run(input int sc, input int lanes);
    int cr_rd = 0, eq_rd = 0, lane_tick = 0, crn, eqn, wait_n;
    bit in_eq = 0, cro, eqo, saw_off = 0;
    logic [7:0] exp_train = 8'h00;
    logic [7:0] rate = 8'h06 + 8'(sc);
    logic [7:0] rev = (sc == 6) ? 8'h10 : 8'h11;
    logic [47:0] st;
    @(negedge clk);
    link_rate = rate; lane_cnt = 3'(lanes); sink_rev = rev; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) begin
      if (!aux_req) begin
        @(negedge clk);
      end else begin
        st = '0;
        aux_err = 1'b0;
        case (aux_addr)
          16'h0100: begin
            chk(!aux_rd && aux_len == 4'd9 && aux_wdata[7:0] == rate, "R1 cfg rate/len",
                int'(aux_wdata[7:0]), int'(rate));
            chk(aux_wdata[15:8] == (8'(lanes) | ((rev >= 8'h11) ? 8'h80 : 8'h00)),
                "R1 cfg lanes/framing", int'(aux_wdata[15:8]), lanes);
            chk(aux_wdata[71:16] == '0, "R1 cfg zero tail", 0, 0);
          end
          16'h0102: begin
            if (aux_wdata[7:0] == 8'd1) begin
              chk(!in_eq && tx_pattern == 2'd1, "R2 pattern 1", int'(tx_pattern), 1);
              chk(tx_swing == exp_train[1:0] && tx_preemph == exp_train[4:3],
                  "R4 tx levels", int'({tx_preemph, tx_swing}),
                  int'({exp_train[4:3], exp_train[1:0]}));
            end else if (aux_wdata[7:0] == 8'd2) begin
              chk(cr_rd > 0 && tx_pattern == 2'd2, "R8 pattern 2", int'(tx_pattern), 2);
              in_eq = 1'b1;
            end else begin
              chk(tx_pattern == 2'd0 && aux_wdata[7:0] == 8'd0, "R10 pattern off",
                  int'(tx_pattern), 0);
              saw_off = 1'b1;
            end
          end
          16'h0103: begin
            for (int i = 0; i < 4; i++)
              chk(aux_wdata[8*i +: 8] == exp_train && aux_len == 4'd4, "R4 R5 lane byte",
                  int'(aux_wdata[8*i +: 8]), int'(exp_train));
          end
          16'h0202: begin
            wait_n = in_eq ? 400 : 100;
            chk(aux_rd && aux_len == 4'd6, "R2 status read", int'(aux_len), 6);
            chk((tick_total - lane_tick) >= wait_n - 1 && (tick_total - lane_tick) <= wait_n + 2,
                in_eq ? "R8 wait ticks" : "R2 wait ticks", tick_total - lane_tick, wait_n);
            st = sink_stat(sc, in_eq, in_eq ? eq_rd : cr_rd);
            if (sc == 5) aux_err = 1'b1;
            if (!exp_pass(st, lanes, in_eq)) exp_train = exp_adjust(st, lanes);
            if (in_eq) eq_rd++; else cr_rd++;
          end
          default: chk(1'b0, "R12 address", int'(aux_addr), 0);
        endcase
        repeat (2) @(negedge clk);
        aux_rdata = st;
        aux_done = 1'b1;
        lane_tick = tick_total;
        @(negedge clk);
        aux_done = 1'b0;
        aux_err = 1'b0;
      end
    end
    expect_out(sc, lanes, crn, eqn, cro, eqo);
    chk(cr_rd == crn, "R6 R7 R11 cr iterations", cr_rd, crn);
    chk(eq_rd == eqn, "R9 R10 eq iterations", eq_rd, eqn);
    chk(cr_ok == cro && eq_ok == eqo && train_fail == !eqo, "R3 R8 R10 result",
        int'({cr_ok, eq_ok, train_fail}), int'({cro, eqo, !eqo}));
    chk(saw_off && tx_pattern == 2'd0, "R10 closing write", int'(saw_off), 1);
    @(negedge clk);
    chk(!busy && !done, "R10 back to idle", int'({busy, done}), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; aux_done = 1'b0; aux_err = 1'b0; aux_rdata = '0;
    link_rate = '0; lane_cnt = 3'd1; sink_rev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !aux_req && !done && tx_pattern == 2'd0 && tx_swing == 2'd0,
        "R12 reset idle", int'({busy, aux_req, done}), 0);
    for (int li = 0; li < 3; li++) begin
      for (int sc = 0; sc < 8; sc++) run(sc, 1 << li);
    end
    summary();
  end
endmodule